// File: doc/BRIEF.md
# Coalescing Translation Lookaside Buffer

This block is a small fully associative translation buffer whose entries each stand for a run of neighbouring virtual pages that map onto neighbouring physical frames. A walker that has missed hands it the virtual page number it was looking for, together with the whole 512-bit line of eight page-table entries that came back from memory. Combinational logic on this fill path finds the longest unbroken stretch of consistent entries that includes the requested page. It then writes one entry with the group tag, a base frame and an 8-bit coverage mask. The neighbours that were not asked for are installed at no extra cost, so the fill also works as a prefetch of nearby translations.

A lookup presents a virtual page number. One cycle later the block returns hit or miss, the physical frame and the permission bits. The frame is the stored base plus the page's position inside its aligned group of eight. Coalescing only changes what is written, so the lookup path has the same depth as in a plain buffer. The frame of a run may start anywhere: it does not have to sit on any large-page boundary.

Top module: `coal_tlb`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every entry is empty and every lookup misses; a fill presented in the same cycle as `flush` is dropped.
- R2: A lookup with `lk_valid` high at a clock edge yields `rsp_valid` high after that edge; with `lk_valid` low, both `rsp_valid` and `rsp_hit` are low after the edge.
- R3: A lookup hits when an entry holds the tag `vpn[VPN_W-1:3]` and its mask bit `vpn[2:0]` is set. `rsp_pfn` is then the entry's base frame plus `vpn[2:0]`, and `rsp_perm` is the entry's permission field.
- R4: Entry layout in `fill_line`: the entry for virtual page `{fill_vpn[VPN_W-1:3], i}` sits at bits `[64*i+63 : 64*i]`. Within an entry, bit 0 is present, bits 3:1 are permissions and bits `[12+PFN_W-1 : 12]` are the frame. If the requested entry (`i = fill_vpn[2:0]`) is not present, the fill writes nothing.
- R5: A neighbour `j` is covered only if it is present, its frame equals the requested frame plus `(j - i)`, its permissions equal the requested ones, and every slot between `j` and `i` is also covered; the mask is therefore one unbroken run through `i`.
- R6: A run is coalesced whatever the alignment of its frames; the base frame is the requested frame minus `i`.
- R7: A fill whose tag is already held overwrites that entry, so there is never more than one entry per group.
- R8: A fill for a new group takes the lowest-numbered empty entry if any; otherwise it replaces the least recently used entry, where both fills and lookup hits count as a use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | VPN_W | Virtual page number that missed |
| fill_line | input | 512 | Eight page-table entries of the aligned group |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_pfn | output | PFN_W | Translated physical frame number |
| rsp_perm | output | 3 | Permission bits of the translation |

## Verification
The hardest state to reach from the ports is a full buffer whose recency order has been changed by a lookup, since only then does the victim differ from simple fill order. The bench flushes the buffer and fills eight fresh groups. It then touches the oldest group with a lookup and fills a ninth group. Afterwards it checks that the second-oldest group is gone while the touched one survives. Broken runs are also hard to reach. They are built from line patterns that combine a frame break, a missing entry and a permission mismatch on both sides of the requested slot. The patterns include a slot that is consistent again beyond a break, which must stay uncovered.

// File: rtl/coal_tlb_pkg.sv
// Package: coal_tlb_pkg
// Shared constants of the coalescing translation buffer: the layout of a
// 64-bit page-table entry and the shape of one fetched line of eight entries.
// Assumes the line always carries exactly eight entries for an aligned group.
package coal_tlb_pkg;
    localparam int unsigned PTE_W     = 64;
    localparam int unsigned LINE_PTES = 8;
    localparam int unsigned IDX_W     = $clog2(LINE_PTES);
    localparam int unsigned LINE_W    = PTE_W * LINE_PTES;
    localparam int unsigned PERM_W    = 3;
    localparam int unsigned PRES_BIT  = 0;
    localparam int unsigned PERM_LSB  = 1;
    localparam int unsigned PFN_LSB   = 12;
endpackage

// File: rtl/coal_tlb_coalesce.sv
// Module: coal_tlb_coalesce
// Purely combinational run finder on the fill path. Given the eight entries
// of one line and the slot that missed, it reports whether that slot is
// present, derives the frame that slot 0 would have (base frame), and builds
// the mask of the unbroken run of consistent slots around the missed one.
// Assumes PFN_LSB + PFN_W <= PTE_W.
module coal_tlb_coalesce
    import coal_tlb_pkg::*;
#(
    parameter int unsigned PFN_W = 28
) (
    input  logic [LINE_W-1:0]    line,
    input  logic [IDX_W-1:0]     req_idx,
    output logic                 req_ok,
    output logic [PFN_W-1:0]     base_pfn,
    output logic [PERM_W-1:0]    run_perm,
    output logic [LINE_PTES-1:0] run_mask
);
    logic [PFN_W-1:0]     slot_pfn  [LINE_PTES];
    logic [PERM_W-1:0]    slot_perm [LINE_PTES];
    logic [LINE_PTES-1:0] slot_pres;
    logic [LINE_PTES-1:0] slot_fit;
    logic                 up_live;
    logic                 dn_live;
    logic                 line_unused;

    // Bits outside the decoded fields carry nothing for this block.
    assign line_unused = ^line;

    // Split every slot into its fields and test it against the requested slot.
    for (genvar g = 0; g < LINE_PTES; g++) begin : g_slot
        assign slot_pres[g] = line[g*PTE_W + PRES_BIT];
        assign slot_perm[g] = line[g*PTE_W + PERM_LSB +: PERM_W];
        assign slot_pfn[g]  = line[g*PTE_W + PFN_LSB +: PFN_W];
        assign slot_fit[g]  = slot_pres[g]
                            && (slot_perm[g] == run_perm)
                            && (slot_pfn[g] == base_pfn + PFN_W'(g));
    end

    // The requested slot defines the translation that neighbours must extend.
    assign req_ok   = slot_pres[req_idx];
    assign run_perm = slot_perm[req_idx];
    assign base_pfn = slot_pfn[req_idx] - PFN_W'(req_idx);

    // Grow the run upward and downward from the requested slot until a misfit.
    always_comb begin
        run_mask = '0;
        up_live  = req_ok;
        dn_live  = req_ok;
        for (int i = 0; i < LINE_PTES; i++) begin
            if (i >= int'(req_idx)) begin
                up_live     = up_live & slot_fit[i];
                run_mask[i] = up_live;
            end
        end
        for (int i = LINE_PTES - 1; i >= 0; i--) begin
            if (i <= int'(req_idx)) begin
                dn_live     = dn_live & slot_fit[i];
                run_mask[i] = run_mask[i] | dn_live;
            end
        end
    end
endmodule

// File: rtl/coal_tlb_lru.sv
// Module: coal_tlb_lru
// Exact least-recently-used order over ENTRIES ways, kept as one age per way
// (0 = most recent, ENTRIES-1 = oldest). Ages always form a permutation, so
// exactly one way is oldest. Assumes ENTRIES >= 2.
module coal_tlb_lru #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned E_W    = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           touch,
    input  logic [E_W-1:0] touch_idx,
    output logic [E_W-1:0] victim
);
    localparam logic [E_W-1:0] OLDEST = E_W'(ENTRIES - 1);

    logic [E_W-1:0]     age [ENTRIES];
    logic [ENTRIES-1:0] is_oldest;

    // Move the touched way to age 0 and push younger ways back by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) age[e] <= E_W'(e);
        end else if (touch) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (E_W'(e) == touch_idx)        age[e] <= '0;
                else if (age[e] < age[touch_idx]) age[e] <= age[e] + 1'b1;
            end
        end
    end

    // Flag and encode the way that holds the oldest age.
    always_comb begin
        victim = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            is_oldest[e] = (age[e] == OLDEST);
            if (is_oldest[e]) victim = E_W'(e);
        end
    end

    // R8: the recency order stays a permutation with a single oldest way.
    a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(is_oldest));
endmodule

// File: rtl/coal_tlb_store.sv
// Module: coal_tlb_store
// Entry array of the buffer: valid flag, group tag, base frame, permissions
// and coverage mask per way. Provides a lookup match vector, the base frame
// and permissions of the matching way, and a tag-only match for fills.
// Assumes at most one way holds a given tag (kept by the caller's way choice).
module coal_tlb_store
    import coal_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned TAG_W   = 33,
    parameter int unsigned PFN_W   = 28,
    localparam int unsigned E_W    = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 we,
    input  logic [E_W-1:0]       wr_sel,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [PFN_W-1:0]     wr_pfn,
    input  logic [PERM_W-1:0]    wr_perm,
    input  logic [LINE_PTES-1:0] wr_mask,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic [IDX_W-1:0]     lk_idx,
    input  logic [TAG_W-1:0]     fl_tag,
    output logic [ENTRIES-1:0]   lk_match,
    output logic [PFN_W-1:0]     lk_base,
    output logic [PERM_W-1:0]    lk_perm,
    output logic [ENTRIES-1:0]   fl_match,
    output logic [ENTRIES-1:0]   valid_vec
);
    logic [TAG_W-1:0]     ent_tag  [ENTRIES];
    logic [PFN_W-1:0]     ent_pfn  [ENTRIES];
    logic [PERM_W-1:0]    ent_perm [ENTRIES];
    logic [LINE_PTES-1:0] ent_mask [ENTRIES];

    // Valid flags: cleared by reset or flush, set by a fill write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid_vec <= '0;
        else if (we)         valid_vec[wr_sel] <= 1'b1;
    end

    // Payload of the written way; no reset needed behind the valid flag.
    always_ff @(posedge clk) begin
        if (we && !flush) begin
            ent_tag[wr_sel]  <= wr_tag;
            ent_pfn[wr_sel]  <= wr_pfn;
            ent_perm[wr_sel] <= wr_perm;
            ent_mask[wr_sel] <= wr_mask;
        end
    end

    // Compare every way against the lookup and fill tags in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_vec[g] && (ent_tag[g] == lk_tag)
                           && ent_mask[g][lk_idx];
        assign fl_match[g] = valid_vec[g] && (ent_tag[g] == fl_tag);
    end

    // OR-select the payload of the (single) matching way.
    always_comb begin
        lk_base = '0;
        lk_perm = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (lk_match[e]) begin
                lk_base = lk_base | ent_pfn[e];
                lk_perm = lk_perm | ent_perm[e];
            end
        end
    end

    // R7: never two ways for one group, so at most one way matches.
    a_r7_one_way_per_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_match) && $onehot0(lk_match));

    // R1: a flush leaves no valid way behind.
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

// File: rtl/coal_tlb.sv
// Module: coal_tlb
// Top of the coalescing translation buffer. Fills run the line through the
// run finder and write one way, chosen as the way already holding the group,
// else the lowest empty way, else the least recently used one. Lookups are
// answered one cycle later from a registered response.
// Assumes ENTRIES >= 2 and VPN_W > 3; flush wins over a same-cycle fill.
module coal_tlb
    import coal_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 36,
    parameter int unsigned PFN_W   = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               lk_valid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [LINE_W-1:0]  fill_line,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PFN_W-1:0]   rsp_pfn,
    output logic [PERM_W-1:0]  rsp_perm
);
    localparam int unsigned E_W   = $clog2(ENTRIES);
    localparam int unsigned TAG_W = VPN_W - IDX_W;

    logic [TAG_W-1:0]     lk_tag, fl_tag;
    logic [IDX_W-1:0]     lk_idx, fl_idx;
    logic                 req_ok;
    logic [PFN_W-1:0]     run_base;
    logic [PERM_W-1:0]    run_perm;
    logic [LINE_PTES-1:0] run_mask;
    logic                 fill_go;
    logic [ENTRIES-1:0]   lk_match, fl_match, valid_vec;
    logic [PFN_W-1:0]     lk_base;
    logic [PERM_W-1:0]    lk_perm;
    logic [E_W-1:0]       victim, tgt, hit_idx;
    logic                 lk_any, free_seen;
    logic                 touch;
    logic [E_W-1:0]       touch_idx;

    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
    assign fl_idx = fill_vpn[IDX_W-1:0];

    coal_tlb_coalesce #(.PFN_W(PFN_W)) u_coalesce (
        .line     (fill_line),
        .req_idx  (fl_idx),
        .req_ok   (req_ok),
        .base_pfn (run_base),
        .run_perm (run_perm),
        .run_mask (run_mask)
    );

    // A fill is taken only if its own entry is present and no flush competes.
    assign fill_go = fill_valid && req_ok && !flush;

    coal_tlb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .we        (fill_go),
        .wr_sel    (tgt),
        .wr_tag    (fl_tag),
        .wr_pfn    (run_base),
        .wr_perm   (run_perm),
        .wr_mask   (run_mask),
        .lk_tag    (lk_tag),
        .lk_idx    (lk_idx),
        .fl_tag    (fl_tag),
        .lk_match  (lk_match),
        .lk_base   (lk_base),
        .lk_perm   (lk_perm),
        .fl_match  (fl_match),
        .valid_vec (valid_vec)
    );

    // Choose the fill way: same group first, then lowest empty, then LRU.
    always_comb begin
        tgt       = victim;
        free_seen = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!free_seen && !valid_vec[e]) begin
                tgt       = E_W'(e);
                free_seen = 1'b1;
            end
        end
        for (int e = 0; e < ENTRIES; e++) begin
            if (fl_match[e]) tgt = E_W'(e);
        end
    end

    // Encode the way a lookup hit in, for the recency update.
    always_comb begin
        hit_idx = '0;
        lk_any  = |lk_match;
        for (int e = 0; e < ENTRIES; e++) begin
            if (lk_match[e]) hit_idx = E_W'(e);
        end
    end

    // A fill marks its way as used; otherwise a lookup hit does.
    assign touch     = fill_go || (lk_valid && lk_any);
    assign touch_idx = fill_go ? tgt : hit_idx;

    coal_tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    // Register the lookup answer: frame is base plus slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_pfn   <= lk_base + PFN_W'(lk_idx);
            rsp_perm  <= lk_perm;
        end
    end

    // R2: a response follows every lookup, and only lookups.
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r2_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

    // R4: an absent requested entry yields an empty run and no write.
    a_r4_absent_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !req_ok) |-> (run_mask == '0));

    // R5: a taken fill always covers the slot that missed.
    a_r5_run_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> run_mask[fl_idx]);

    // R3: a lookup issued right after a fill of that exact page must hit.
    a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !flush) |=> ((lk_valid && lk_vpn == $past(fill_vpn)) |-> lk_any));
endmodule

// File: tb/coal_tlb_tb.sv
`timescale 1ns/1ps
module coal_tlb_tb;
    localparam int unsigned VPN_W = 36;
    localparam int unsigned PFN_W = 28;
    localparam int unsigned NV    = 22;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [511:0]     fill_line = '0;
    logic             rsp_valid, rsp_hit;
    logic [PFN_W-1:0] rsp_pfn;
    logic [2:0]       rsp_perm;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    coal_tlb #(.ENTRIES(8), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_line(fill_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm)
    );

    // One step: fill (vpn, pfn0, present, frame-break, perm-differ masks)
    // or lookup (vpn, expected hit, expected frame).
    typedef struct packed {
        logic             is_fill;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn0;
        logic [7:0]       pres;
        logic [7:0]       brk;
        logic [7:0]       pdif;
        logic             exp_hit;
        logic [PFN_W-1:0] exp_pfn;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 36'h00012, 28'h500, 8'hFF, 8'h00, 8'h00, 1'b0, 28'h0},   // R5 full run
        '{1'b0, 36'h00010, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h500}, // R3
        '{1'b0, 36'h00017, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h507}, // R3
        '{1'b0, 36'h00018, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R3 other group
        '{1'b1, 36'h00023, 28'h800, 8'hFF, 8'h41, 8'h00, 1'b0, 28'h0},   // R5 breaks at 0,6
        '{1'b0, 36'h00021, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h801}, // R5
        '{1'b0, 36'h00025, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h805}, // R5
        '{1'b0, 36'h00020, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R5 frame break
        '{1'b0, 36'h00027, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R5 beyond break
        '{1'b1, 36'h00034, 28'hA00, 8'hFB, 8'h00, 8'h40, 1'b0, 28'h0},   // R5 hole 2, perm 6
        '{1'b0, 36'h00033, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'hA03}, // R5
        '{1'b0, 36'h00035, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'hA05}, // R5
        '{1'b0, 36'h00036, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R5 perm differs
        '{1'b0, 36'h00032, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R5 not present
        '{1'b1, 36'h00040, 28'hC00, 8'hFE, 8'h00, 8'h00, 1'b0, 28'h0},   // R4 req absent
        '{1'b0, 36'h00041, 28'h0,   8'h0,  8'h0,  8'h0,  1'b0, 28'h0},   // R4
        '{1'b1, 36'h00057, 28'h123, 8'hFF, 8'h00, 8'h00, 1'b0, 28'h0},   // R6 unaligned
        '{1'b0, 36'h00050, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h123}, // R6
        '{1'b0, 36'h00057, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h12A}, // R6
        '{1'b1, 36'h00011, 28'h600, 8'hFF, 8'h00, 8'h00, 1'b0, 28'h0},   // R7 refill group
        '{1'b0, 36'h00012, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h602}, // R7
        '{1'b0, 36'h00016, 28'h0,   8'h0,  8'h0,  8'h0,  1'b1, 28'h606}  // R7
    };

    // Build a line: slot i present per pres, frame pfn0+i (+100 if broken),
    // permissions 3'b011, or 3'b001 where pdif is set (layout per R4).
    function automatic logic [511:0] mk_line(logic [PFN_W-1:0] pfn0,
                                             logic [7:0] pres,
                                             logic [7:0] brk,
                                             logic [7:0] pdif);
        logic [511:0] l;
        l = '0;
        for (int i = 0; i < 8; i++) begin
            l[i*64]          = pres[i];
            l[i*64+1 +: 3]   = pdif[i] ? 3'b001 : 3'b011;
            l[i*64+12 +: 28] = pfn0 + PFN_W'(i) + (brk[i] ? 28'd100 : 28'd0);
            l[i*64+60]       = 1'b1;
        end
        return l;
    endfunction

    task automatic note(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [511:0] line);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_line  = line;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_look(input logic [VPN_W-1:0] vpn, input bit exp_hit,
                           input logic [PFN_W-1:0] exp_pfn, input string req);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        @(negedge clk);
        lk_valid = 1'b0;
        note(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        note(rsp_hit == exp_hit, req, $sformatf("hit vpn %0h", vpn),
             32'(rsp_hit), 32'(exp_hit));
        if (exp_hit && rsp_hit) begin
            note(rsp_pfn == exp_pfn, req, $sformatf("pfn vpn %0h", vpn),
                 32'(rsp_pfn), 32'(exp_pfn));
            note(rsp_perm == 3'b011, "R3", "perm", 32'(rsp_perm), 32'd3);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the response.
        note(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R1", "reset rsp",
             32'({rsp_valid, rsp_hit}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_look(36'h00010, 1'b0, '0, "R1");

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_fill)
                do_fill(VECS[k].vpn, mk_line(VECS[k].pfn0, VECS[k].pres,
                                             VECS[k].brk, VECS[k].pdif));
            else
                do_look(VECS[k].vpn, VECS[k].exp_hit, VECS[k].exp_pfn, "R3/R5");
        end

        // R2: idle cycle gives no response.
        @(negedge clk);
        note(rsp_valid == 1'b0, "R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R1: flush with a simultaneous fill; both old and new groups miss.
        flush      = 1'b1;
        fill_valid = 1'b1;
        fill_vpn   = 36'h00090;
        fill_line  = mk_line(28'h900, 8'hFF, 8'h00, 8'h00);
        @(negedge clk);
        flush      = 1'b0;
        fill_valid = 1'b0;
        do_look(36'h00012, 1'b0, '0, "R1");
        do_look(36'h00090, 1'b0, '0, "R1");

        // R8: fill eight groups, touch the oldest, add a ninth.
        for (int g = 0; g < 8; g++)
            do_fill(36'h1000 + VPN_W'(g*8), mk_line(28'h4000 + PFN_W'(g*16),
                                                    8'hFF, 8'h00, 8'h00));
        do_look(36'h1003, 1'b1, 28'h4003, "R8");
        do_fill(36'h1040, mk_line(28'h4080, 8'hFF, 8'h00, 8'h00));
        do_look(36'h1009, 1'b0, '0, "R8");
        do_look(36'h1001, 1'b1, 28'h4001, "R8");
        do_look(36'h1012, 1'b1, 28'h4022, "R8");
        do_look(36'h1047, 1'b1, 28'h4087, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule